// File: doc/BRIEF.md
# Clock Recovery Lock Supervisor

This block is the digital supervisor of a clock recovery loop. It decides whether the loop should track the incoming serial data or hold on the local reference clock. It also reports whether the loop is locked. The analog loop and the glitch-free clock multiplexer sit outside the block. They take `sel_data` as their source choice.

After reset, the supervisor holds the loop on the reference for a timed acquisition period. That period is measured in ticks of a slow millisecond-scale timebase. A request input restarts the period while it is held. Once the period ends, the supervisor tracks data. While tracking, it watches the sampled serial bits for two conditions: a run of identical bits that is too long, and too few transitions in a fixed window of bits. Either condition drops lock. The loop then returns to the reference, and the full timed acquisition must run again. Phase steps in the data are never a reason to drop lock.

The state sequence is RESET, then REF_ACQUIRE, then DATA_TRACK. A loss of lock in DATA_TRACK leads back to REF_ACQUIRE. The reset is asynchronous and active low. Its release is synchronised inside the block and takes two clock edges.

Top module: `lock_supervisor`

## Requirements
- R1: While `rst_n` is low, and for the first cycles after its release, `locked` and `sel_data` are both low.
- R2: In REF_ACQUIRE, `ms_tick` (a one-cycle active-high pulse) is counted only in a cycle where `ref_req` is low. The block enters DATA_TRACK at the clock edge that samples the ACQ_TICKS-th counted tick. `locked` and `sel_data` are high from the following cycle.
- R3: A cycle with `ref_req` high (active high) during REF_ACQUIRE clears the tick count. A tick sampled in such a cycle is not counted.
- R4: `ref_req` sampled high during DATA_TRACK returns the block to REF_ACQUIRE at that clock edge.
- R5: In DATA_TRACK, consecutive identical values of `bit_in` are counted from the first bit sampled after entry. A run of RUN_LIMIT bits keeps lock. The edge that samples the RUN_LIMIT+1-th identical bit returns the block to REF_ACQUIRE.
- R6: In DATA_TRACK, bits are grouped into back-to-back windows of WIN_BITS bits, starting at the first bit after entry. A transition is a sampled bit that differs from the previously sampled bit; the first bit after entry carries none. If a window holds fewer than MIN_TRANS transitions, the edge that samples its last bit returns the block to REF_ACQUIRE.
- R7: A transition between the last bit of one window and the first bit of the next counts toward the next window. The count starts again at every window.
- R8: A phase step in the data does not by itself drop lock, as long as the run and density limits hold. A phase step here means a repeated or skipped bit in a regular pattern.
- R9: After any loss of lock, `sel_data` stays low until a fresh, complete count of ACQ_TICKS ticks has been made.
- R10: `locked` and `sel_data` are always equal, and both are high exactly in DATA_TRACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit is sampled per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Sampled serial data bit |
| ref_req | input | 1 | Active-high request to (re)start acquisition on the reference |
| ms_tick | input | 1 | One-cycle pulse from the slow timebase |
| locked | output | 1 | High while the loop tracks data |
| sel_data | output | 1 | Tracking source select: 1 = data, 0 = reference |

## Verification
Every result of this block becomes visible one clock edge after the input that causes it. This holds for entering DATA_TRACK on the last counted tick, for the drop on the RUN_LIMIT+1-th identical bit, for the drop on the last bit of a sparse window, and for the drop on a request. The bench changes inputs on the falling edge and samples the outputs at the next falling edge, so each sample reflects exactly one rising edge. It keeps its own index of tracked bits and computes the index at which a drop is due from the run lengths it constructs. It then checks `locked` after every single bit, so a drop one bit early or one bit late is reported.

// File: rtl/lock_sup_pkg.sv
package lock_sup_pkg;
  typedef enum logic [1:0] {
    ST_RESET      = 2'd0,
    ST_REF_ACQ    = 2'd1,
    ST_DATA_TRACK = 2'd2
  } sup_state_e;
endpackage

// File: rtl/lsup_rst_sync.sv
module lsup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lsup_acq_timer.sv
module lsup_acq_timer #(
  parameter int ACQ_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic restart,
  input  logic tick,
  output logic done
);
  localparam int CW = (ACQ_TICKS > 1) ? $clog2(ACQ_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACQ_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          counting;

  assign counting = run_en && !restart;
  assign done     = counting && tick && (cnt_q == LAST);
  assign cnt_en   = !counting || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!counting)  cnt_d = '0;
    else if (done)  cnt_d = '0;
    else if (tick)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lsup_run_mon.sv
module lsup_run_mon #(
  parameter int RUN_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_in,
  output logic fault
);
  localparam int RW = $clog2(RUN_LIMIT + 2);
  localparam logic [RW-1:0] LIM = RW'(RUN_LIMIT);

  logic [RW-1:0] run_q, run_d;
  logic          prev_q, prev_d;
  logic          same;

  assign same  = (run_q != '0) && (bit_in == prev_q);
  assign fault = active && same && (run_q == LIM);

  always_comb begin
    run_d  = '0;
    prev_d = 1'b0;
    if (active) begin
      prev_d = bit_in;
      if (!same)            run_d = RW'(1);
      else if (run_q < LIM) run_d = run_q + 1'b1;
      else                  run_d = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/lsup_density_mon.sv
module lsup_density_mon #(
  parameter int WIN_BITS  = 100,
  parameter int MIN_TRANS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_in,
  output logic fault
);
  localparam int IW = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;
  localparam int TW = $clog2(WIN_BITS + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(WIN_BITS - 1);
  localparam logic [TW-1:0] TMIN     = TW'(MIN_TRANS);

  logic [IW-1:0] idx_q, idx_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          prev_q, prev_d;
  logic          seen_q, seen_d;
  logic          is_tr;
  logic          win_end;
  logic [TW-1:0] tsum;

  assign is_tr   = active && seen_q && (bit_in != prev_q);
  assign tsum    = tcnt_q + TW'(is_tr);
  assign win_end = (idx_q == IDX_LAST);
  assign fault   = active && win_end && (tsum < TMIN);

  always_comb begin
    idx_d  = '0;
    tcnt_d = '0;
    prev_d = 1'b0;
    seen_d = 1'b0;
    if (active) begin
      prev_d = bit_in;
      seen_d = 1'b1;
      if (!win_end) begin
        idx_d  = idx_q + 1'b1;
        tcnt_d = tsum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      tcnt_q <= '0;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      tcnt_q <= tcnt_d;
      prev_q <= prev_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/lsup_fsm.sv
module lsup_fsm
  import lock_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_done,
  input  logic       req,
  input  logic       run_fault,
  input  logic       dens_fault,
  output sup_state_e state
);
  sup_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:      state_d = ST_REF_ACQ;
      ST_REF_ACQ:    if (acq_done) state_d = ST_DATA_TRACK;
      ST_DATA_TRACK: if (req || run_fault || dens_fault) state_d = ST_REF_ACQ;
      default:       state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
  import lock_sup_pkg::*;
#(
  parameter int ACQ_TICKS = 10,
  parameter int RUN_LIMIT = 64,
  parameter int WIN_BITS  = 100,
  parameter int MIN_TRANS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic ref_req,
  input  logic ms_tick,
  output logic locked,
  output logic sel_data
);
  logic       rst_n_int;
  sup_state_e state;
  logic       acq_done;
  logic       run_fault;
  logic       dens_fault;
  logic       in_acq;
  logic       in_track;

  assign in_acq   = (state == ST_REF_ACQ);
  assign in_track = (state == ST_DATA_TRACK);

  lsup_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lsup_acq_timer #(.ACQ_TICKS(ACQ_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .run_en  (in_acq),
    .restart (ref_req),
    .tick    (ms_tick),
    .done    (acq_done)
  );

  lsup_run_mon #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .active (in_track),
    .bit_in (bit_in),
    .fault  (run_fault)
  );

  lsup_density_mon #(.WIN_BITS(WIN_BITS), .MIN_TRANS(MIN_TRANS)) u_dens (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .active (in_track),
    .bit_in (bit_in),
    .fault  (dens_fault)
  );

  lsup_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .acq_done   (acq_done),
    .req        (ref_req),
    .run_fault  (run_fault),
    .dens_fault (dens_fault),
    .state      (state)
  );

  assign locked   = in_track;
  assign sel_data = in_track;
endmodule

// File: rtl/lock_supervisor_chk.sv
module lock_supervisor_chk #(
  parameter int RUN_LIMIT = 64
) (
  input logic clk,
  input logic rst_n,
  input logic bit_in,
  input logic ref_req,
  input logic ms_tick,
  input logic locked,
  input logic sel_data
);
  localparam int CRW = $clog2(RUN_LIMIT + 2);

  logic [CRW-1:0] ck_run;
  logic           ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_run  <= '0;
      ck_prev <= 1'b0;
    end else if (locked) begin
      ck_prev <= bit_in;
      if (ck_run != '0 && bit_in == ck_prev && ck_run != CRW'(RUN_LIMIT + 1))
        ck_run <= ck_run + 1'b1;
      else if (!(ck_run != '0 && bit_in == ck_prev))
        ck_run <= CRW'(1);
    end else begin
      ck_run  <= '0;
      ck_prev <= 1'b0;
    end
  end

  p_same_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked == sel_data);

  p_req_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked && ref_req |=> !locked);

  p_entry_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(ms_tick) && !$past(ref_req)));

  p_no_tick_no_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && !ms_tick |=> !locked);

  p_run_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked && ck_run == CRW'(RUN_LIMIT) && bit_in == ck_prev |=> !locked);
endmodule

bind lock_supervisor lock_supervisor_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_in   (bit_in),
  .ref_req  (ref_req),
  .ms_tick  (ms_tick),
  .locked   (locked),
  .sel_data (sel_data)
);

// File: tb/test_lock_supervisor.sv
module test_lock_supervisor;
  localparam int ACQ  = 4;
  localparam int RUNL = 6;
  localparam int WIN  = 24;
  localparam int MINT = 5;

  logic clk;
  logic rst_n;
  logic bit_in;
  logic ref_req;
  logic ms_tick;
  logic locked;
  logic sel_data;

  int n_chk;
  int n_fail;
  int trk;
  bit done;

  lock_supervisor #(
    .ACQ_TICKS(ACQ), .RUN_LIMIT(RUNL), .WIN_BITS(WIN), .MIN_TRANS(MINT)
  ) i_lock_supervisor (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .ref_req(ref_req),
    .ms_tick(ms_tick), .locked(locked), .sel_data(sel_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic b, input logic t, input logic r);
    bit_in = b; ms_tick = t; ref_req = r;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0);
    drive(0, 1, 0);
    check(locked, 1'b0, "R1");
    check(sel_data, 1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 0);
      check(locked, 1'b0, "R1");
    end
  endtask

  // counts ACQ ticks; lock is due right after the last one
  task automatic acquire(input string req);
    for (int k = 1; k <= ACQ; k++) begin
      drive(1, 0, 0);
      check(sel_data, 1'b0, req);
      drive(0, 0, 0);
      drive(1, 1, 0);
      check(locked, (k == ACQ) ? 1'b1 : 1'b0, req);
      check(sel_data, (k == ACQ) ? 1'b1 : 1'b0, "R10");
    end
    trk = 0;
  endtask

  task automatic bit_chk(input logic b, input int fail_idx, input string req);
    drive(b, 0, 0);
    check(locked, (trk == fail_idx) ? 1'b0 : 1'b1, req);
    trk++;
  endtask

  task automatic runs(input int nr, input int lens[8], input logic start,
                      input int fail_idx, input string req);
    logic v;
    v = start;
    for (int r = 0; r < nr; r++) begin
      for (int i = 0; i < lens[r]; i++) bit_chk(v, fail_idx, req);
      v = ~v;
    end
  endtask

  initial begin
    int lens[8];
    n_chk = 0; n_fail = 0; done = 0; trk = 0;
    rst_n = 1'b1; bit_in = 0; ref_req = 0; ms_tick = 0;
    #1 rst_n = 1'b0;
    @(negedge clk);

    // R1, R2
    do_reset();
    acquire("R2");

    // R3: request clears the count, tick with request not counted
    do_reset();
    for (int k = 0; k < ACQ - 1; k++) drive(0, 1, 0);
    drive(0, 1, 1);
    check(locked, 1'b0, "R3");
    for (int k = 0; k < ACQ - 1; k++) begin
      drive(0, 1, 0);
      check(locked, 1'b0, "R3");
    end
    drive(0, 1, 0);
    check(locked, 1'b1, "R3");

    // R4: request during tracking
    drive(1, 0, 1);
    check(locked, 1'b0, "R4");
    check(sel_data, 1'b0, "R10");

    // R5: run sweep, both polarities, runs 1..RUNL+1
    for (int pol = 0; pol < 2; pol++) begin
      do_reset();
      acquire("R2");
      for (int i = 0; i < 4; i++) bit_chk(logic'((i + pol) % 2), -1, "R5");
      for (int j = 1; j <= RUNL; j++)
        bit_chk(logic'((3 + pol) % 2), 3 + RUNL, "R5");
      // R9: no relock without a full fresh count
      for (int i = 0; i < 5; i++) begin
        drive(0, 0, 0);
        check(sel_data, 1'b0, "R9");
      end
      acquire("R9");
    end

    // R6: density sweep, n transitions in the first window
    for (int n = 3; n <= 8; n++) begin
      do_reset();
      acquire("R2");
      for (int r = 0; r < 8; r++)
        lens[r] = (r <= n) ? (WIN / (n + 1) + ((r < WIN % (n + 1)) ? 1 : 0)) : 0;
      runs(n + 1, lens, 1'b0, (n < MINT) ? WIN - 1 : -1, "R6");
    end

    // R7 case A: boundary transition counts toward second window
    do_reset();
    acquire("R2");
    for (int r = 0; r < 8; r++) lens[r] = (r < 6) ? 4 : 0;
    runs(6, lens, 1'b0, -1, "R7");
    lens[0] = 5; lens[1] = 5; lens[2] = 5; lens[3] = 5; lens[4] = 4;
    runs(5, lens, 1'b0, -1, "R7");

    // R7 case B: no boundary transition, only MINT-1 inside -> drop
    do_reset();
    acquire("R2");
    for (int r = 0; r < 8; r++) lens[r] = (r < 6) ? 4 : 0;
    runs(6, lens, 1'b0, -1, "R7");
    lens[0] = 2; lens[1] = 6; lens[2] = 6; lens[3] = 6; lens[4] = 4;
    runs(5, lens, 1'b1, 2 * WIN - 1, "R7");

    // R8: alternating data with phase slips (repeated bits, inversion steps)
    do_reset();
    acquire("R2");
    begin
      logic v;
      v = 1'b0;
      for (int i = 0; i < 3 * WIN; i++) begin
        bit_chk(v, -1, "R8");
        if (i % 5 != 4) v = ~v;
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule